// File: doc/BRIEF.md
# Command Register Copy Engine

This block moves the register-map portion of a queued command from a command-queue slot in memory into the address window of one compute unit. A control processor posts a slot index on a trigger input and is then free to do other work. The engine reads the slot's header word and its mandatory unit-mask word, decodes the target unit, and copies each register-map word through a single-outstanding memory master: one read from the slot, then one write to the unit. It signals completion with a one-cycle done pulse, or a one-cycle error pulse when the command cannot be delivered.

Configuration arrives on plain input ports: an enable, the queue base address, the slot size in bytes, the base address of the first unit and the per-unit address shift. One trigger can wait in a one-deep holding register while a copy is in progress.

The controller has seven states. `ST_IDLE` waits for a held trigger. Taking one (transition *accept*) moves to `ST_HDR`, which reads the header. A nonzero opcode takes the *bad-op* transition to `ST_FAULT`; otherwise `ST_MASK` reads the mask word. A zero mask takes *no-unit* to `ST_FAULT`. An empty register map takes *empty* to `ST_DONE`. Otherwise the *copy* transition enters `ST_RD`. `ST_RD` leads by *fetched* to `ST_WR`. `ST_WR` returns by *next* to `ST_RD` or ends by *last* in `ST_DONE`. `ST_DONE` and `ST_FAULT` each return to `ST_IDLE` after one cycle (*retire*).

Top module: `cu_regcopy_engine`

## Requirements
- R1: A trigger (`trig_valid` high for one cycle) is taken only while `cfg_enable` is 1. With `cfg_enable` at 0 the trigger is ignored: no memory request, no busy, no done or error.
- R2: The slot byte address is `cfg_queue_base + trig_slot * cfg_slot_bytes`. The header is read at the slot address and the mandatory mask at slot address + 4.
- R3: Header fields are: word count in bits [22:12], extra-mask count in bits [11:10], opcode in bits [27:23]. An opcode other than 0 ends the command with an error pulse and no write.
- R4: The register map holds count − (1 + extra) words, or zero words when count < 1 + extra. Word i is read from slot address + 4·(2 + extra + i), and the words are written in ascending i.
- R5: The target unit index is the position of the lowest set bit of the mask word. Word i is written to `cfg_unit_base + (index << cfg_unit_shift) + 4·i`.
- R6: A mask word of zero ends the command with an error pulse and no write.
- R7: `done` pulses for exactly one cycle after the last write is acknowledged. A zero-length register map gives `done` with no write.
- R8: `busy` is high from the cycle after a trigger is taken out of the holding register until the done or error cycle. The memory master has at most one request open, and holds `mem_req`, `mem_we` and `mem_addr` steady until `mem_ack`.
- R9: One trigger that arrives while a copy runs is held and executed afterwards. A further trigger arriving while that one is still held is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Accept triggers when 1 |
| cfg_queue_base | input | 32 | Byte address of slot 0 |
| cfg_slot_bytes | input | 32 | Slot size in bytes |
| cfg_unit_base | input | 32 | Byte address of unit 0 |
| cfg_unit_shift | input | 5 | log2 of one unit's address window |
| trig_valid | input | 1 | Trigger strobe |
| trig_slot | input | 8 | Slot index of the trigger |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completes this cycle; read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle failure pulse |

## Verification
The copy is tried with a plain one-mask command, which separates the register-map offset and the unit stride from the slot offset. A command with two extra masks, a two-bit unit mask, a different slot size and a different shift, under slow memory acknowledges, tells the lowest-bit pick from any other and shows whether the extra-mask count moves the source start. Zero-length and under-count headers tell the clamp from a wrapped subtraction. A zero mask and a nonzero opcode tell the two fault paths from a copy. Three back-to-back triggers tell the one-deep hold from a deeper or a missing one, and a trigger with the enable off tells gating from none.

// File: rtl/rce_pkg.sv
package rce_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_MASK,
        ST_RD,
        ST_WR,
        ST_DONE,
        ST_FAULT
    } rce_state_e;

    localparam int HDR_CNT_LSB   = 12;
    localparam int HDR_CNT_W     = 11;
    localparam int HDR_XTRA_LSB  = 10;
    localparam int HDR_XTRA_W    = 2;
    localparam int HDR_OP_LSB    = 23;
    localparam int HDR_OP_W      = 5;
    localparam int OP_START_UNIT = 0;

    function automatic logic [HDR_CNT_W-1:0] hdr_count(input logic [31:0] h);
        return h[HDR_CNT_LSB +: HDR_CNT_W];
    endfunction

    function automatic logic [HDR_XTRA_W-1:0] hdr_extra(input logic [31:0] h);
        return h[HDR_XTRA_LSB +: HDR_XTRA_W];
    endfunction

    function automatic logic [HDR_OP_W-1:0] hdr_opcode(input logic [31:0] h);
        return h[HDR_OP_LSB +: HDR_OP_W];
    endfunction

endpackage

// File: rtl/rce_pending_trig.sv
module rce_pending_trig #(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [SLOT_W-1:0] push_slot,
    input  logic              pop,
    output logic              held,
    output logic [SLOT_W-1:0] held_slot
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held      <= 1'b0;
            held_slot <= '0;
        end else if (push && (!held || pop)) begin
            held      <= 1'b1;
            held_slot <= push_slot;
        end else if (pop) begin
            held      <= 1'b0;
        end
    end

    // R9: a held trigger is neither lost nor overwritten until it is taken
    assert_pend_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !pop) |=> (held && $stable(held_slot)));

endmodule

// File: rtl/rce_prio_enc.sv
module rce_prio_enc #(
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] mask,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int b = WIDTH - 1; b >= 0; b--) begin
            if (mask[b]) begin
                found = 1'b1;
                idx   = IDX_W'(b);
            end
        end
    end

    // R5: the chosen index always points at a set mask bit
    always_comb begin
        if (found) begin
            assert_prio_hit_R5: assert (mask[idx]);
        end
    end

endmodule

// File: rtl/rce_addr_gen.sv
module rce_addr_gen #(
    parameter int AW      = 32,
    parameter int SLOT_W  = 8,
    parameter int IDX_W   = 5,
    parameter int SHIFT_W = 5
) (
    input  logic [SLOT_W-1:0]  slot,
    input  logic [AW-1:0]      queue_base,
    input  logic [AW-1:0]      slot_bytes,
    input  logic [AW-1:0]      unit_base,
    input  logic [IDX_W-1:0]   unit_idx,
    input  logic [SHIFT_W-1:0] unit_shift,
    output logic [AW-1:0]      slot_addr,
    output logic [AW-1:0]      unit_addr
);

    always_comb begin
        slot_addr = queue_base + AW'(slot) * slot_bytes;
        unit_addr = unit_base + (AW'(unit_idx) << unit_shift);
    end

endmodule

// File: rtl/cu_regcopy_engine.sv
module cu_regcopy_engine
    import rce_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int SLOT_W  = 8,
    parameter int SHIFT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_enable,
    input  logic [AW-1:0]      cfg_queue_base,
    input  logic [AW-1:0]      cfg_slot_bytes,
    input  logic [AW-1:0]      cfg_unit_base,
    input  logic [SHIFT_W-1:0] cfg_unit_shift,
    input  logic               trig_valid,
    input  logic [SLOT_W-1:0]  trig_slot,
    output logic               mem_req,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata,
    input  logic               mem_ack,
    input  logic [DW-1:0]      mem_rdata,
    output logic               busy,
    output logic               done,
    output logic               error
);

    localparam int IDX_W  = $clog2(DW);
    localparam int BYTE_SH = $clog2(DW / 8);
    localparam int MAP_OFS = 2;

    rce_state_e state_q, state_d;

    logic              held;
    logic [SLOT_W-1:0] held_slot;
    logic              take;

    logic [AW-1:0]        slot_addr, unit_addr;
    logic [AW-1:0]        slot_base_q, unit_addr_q;
    logic [HDR_CNT_W-1:0] cnt_q, len_q, word_q, len_calc;
    logic [HDR_XTRA_W-1:0] xtra_q;
    logic [DW-1:0]        data_q;
    logic                 unit_found;
    logic [IDX_W-1:0]     unit_idx;
    logic                 last_word;
    logic                 bad_op;

    assign take = (state_q == ST_IDLE) && held;

    rce_pending_trig #(.SLOT_W(SLOT_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (trig_valid && cfg_enable),
        .push_slot (trig_slot),
        .pop       (take),
        .held      (held),
        .held_slot (held_slot)
    );

    rce_prio_enc #(.WIDTH(DW)) u_enc (
        .mask  (mem_rdata),
        .found (unit_found),
        .idx   (unit_idx)
    );

    rce_addr_gen #(
        .AW(AW), .SLOT_W(SLOT_W), .IDX_W(IDX_W), .SHIFT_W(SHIFT_W)
    ) u_addr (
        .slot       (held_slot),
        .queue_base (cfg_queue_base),
        .slot_bytes (cfg_slot_bytes),
        .unit_base  (cfg_unit_base),
        .unit_idx   (unit_idx),
        .unit_shift (cfg_unit_shift),
        .slot_addr  (slot_addr),
        .unit_addr  (unit_addr)
    );

    // register-map length with clamp at zero
    always_comb begin
        logic [HDR_CNT_W-1:0] need;
        need = HDR_CNT_W'(xtra_q) + HDR_CNT_W'(1);
        len_calc = (cnt_q >= need) ? (cnt_q - need) : '0;
    end

    assign last_word = (word_q == len_q - HDR_CNT_W'(1));
    assign bad_op    = (hdr_opcode(mem_rdata) != HDR_OP_W'(OP_START_UNIT));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (held) state_d = ST_HDR;
            ST_HDR:   if (mem_ack) state_d = bad_op ? ST_FAULT : ST_MASK;
            ST_MASK:  if (mem_ack) begin
                          if (!unit_found)            state_d = ST_FAULT;
                          else if (len_calc == '0)    state_d = ST_DONE;
                          else                        state_d = ST_RD;
                      end
            ST_RD:    if (mem_ack) state_d = ST_WR;
            ST_WR:    if (mem_ack) state_d = last_word ? ST_DONE : ST_RD;
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_base_q <= '0;
            unit_addr_q <= '0;
            cnt_q       <= '0;
            xtra_q      <= '0;
            len_q       <= '0;
            word_q      <= '0;
            data_q      <= '0;
        end else begin
            if (take) begin
                slot_base_q <= slot_addr;
            end
            if (state_q == ST_HDR && mem_ack) begin
                cnt_q  <= hdr_count(mem_rdata);
                xtra_q <= hdr_extra(mem_rdata);
            end
            if (state_q == ST_MASK && mem_ack) begin
                unit_addr_q <= unit_addr;
                len_q       <= len_calc;
                word_q      <= '0;
            end
            if (state_q == ST_RD && mem_ack) begin
                data_q <= mem_rdata;
            end
            if (state_q == ST_WR && mem_ack) begin
                word_q <= word_q + HDR_CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = data_q;
        busy      = (state_q != ST_IDLE);
        done      = 1'b0;
        error     = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_HDR: begin
                mem_req  = 1'b1;
                mem_addr = slot_base_q;
            end
            ST_MASK: begin
                mem_req  = 1'b1;
                mem_addr = slot_base_q + AW'(DW / 8);
            end
            ST_RD: begin
                mem_req  = 1'b1;
                mem_addr = slot_base_q
                         + ((AW'(xtra_q) + AW'(word_q) + AW'(MAP_OFS)) << BYTE_SH);
            end
            ST_WR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = unit_addr_q + (AW'(word_q) << BYTE_SH);
            end
            ST_DONE:  done  = 1'b1;
            ST_FAULT: error = 1'b1;
            default:  ;
        endcase
    end

    // R8: an open request is held unchanged until acknowledged
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R8: no memory traffic while not busy
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R7: completion pulse lasts one cycle and returns to idle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R6: a zero mask word yields an error pulse next cycle
    assert_zero_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MASK && mem_ack && mem_rdata == '0) |=> (error && !done));

    // R3: a write never follows a header with a nonzero opcode
    assert_bad_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HDR && mem_ack && bad_op) |=> (error && !mem_req));

    // R5: writes land inside the selected unit's window start or above
    assert_write_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr >= unit_addr_q));

endmodule

// File: tb/cu_regcopy_engine_test.sv
module cu_regcopy_engine_test;

    localparam logic [31:0] QBASE = 32'h0000_1000;
    localparam logic [31:0] UBASE = 32'h0100_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [31:0] cfg_queue_base = QBASE;
    logic [31:0] cfg_slot_bytes = 32'h80;
    logic [31:0] cfg_unit_base = UBASE;
    logic [4:0]  cfg_unit_shift = 5'd16;
    logic        trig_valid = 1'b0;
    logic [7:0]  trig_slot = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        busy, done, error;

    always #2 clk = ~clk;

    cu_regcopy_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
        .cfg_queue_base(cfg_queue_base), .cfg_slot_bytes(cfg_slot_bytes),
        .cfg_unit_base(cfg_unit_base), .cfg_unit_shift(cfg_unit_shift),
        .trig_valid(trig_valid), .trig_slot(trig_slot),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .error(error)
    );

    int n_chk = 0, n_fail = 0;
    logic [31:0] qmem [0:1023];
    logic [31:0] wl_addr [0:63];
    logic [31:0] wl_data [0:63];
    int wl_n = 0, n_done = 0, n_err = 0, n_rdreq = 0;
    int lat = 0, waitc = 0, cyc = 0;
    bit saw_busy = 0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (a >= QBASE && a < QBASE + 32'd4096) return qmem[(a - QBASE) >> 2];
        return 32'hBAD0_0000;
    endfunction

    function automatic logic [31:0] mk_hdr(input int cnt, input int xtra, input int op);
        return (32'(op) << 23) | (32'(cnt) << 12) | (32'(xtra) << 10) | 32'h1;
    endfunction

    // memory model and monitors, all on the falling edge
    initial begin
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (done) n_done++;
            if (error) n_err++;
            if (busy) saw_busy = 1;
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (waitc < lat) waitc++;
                else begin
                    waitc = 0;
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        if (wl_n < 64) begin
                            wl_addr[wl_n] = mem_addr;
                            wl_data[wl_n] = mem_wdata;
                        end
                        wl_n++;
                    end else begin
                        n_rdreq++;
                        mem_rdata = rd(mem_addr);
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic trig(input logic [7:0] s);
        @(negedge clk);
        trig_valid = 1'b1;
        trig_slot  = s;
        @(negedge clk);
        trig_valid = 1'b0;
    endtask

    task automatic wait_ends(input int total);
        for (int i = 0; i < 2000 && (n_done + n_err) < total; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_slot(input int s, input int bytes);
        for (int i = 0; i < 16; i++) qmem[(s * bytes) / 4 + i] = 32'h0;
    endtask

    task automatic t_reset;
        chk(busy == 0, "R8", "busy after reset", 32'(busy), 0);
        chk(done == 0 && error == 0, "R7", "done/error after reset",
            {30'd0, done, error}, 0);
        chk(mem_req == 0, "R8", "mem_req after reset", 32'(mem_req), 0);
    endtask

    task automatic t_basic;
        int b, d0, e0, w0;
        b = 2 * 32;
        qmem[b]   = mk_hdr(4, 0, 0);
        qmem[b+1] = 32'h1 << 5;
        qmem[b+2] = 32'hA000_0000;
        qmem[b+3] = 32'hA000_0001;
        qmem[b+4] = 32'hA000_0002;
        d0 = n_done; e0 = n_err; w0 = wl_n; saw_busy = 0;
        trig(8'd2);
        wait_ends(d0 + e0 + 1);
        chk(n_done == d0 + 1 && n_err == e0, "R7", "basic done count", 32'(n_done - d0), 1);
        chk(saw_busy, "R8", "busy during copy", 32'(saw_busy), 1);
        chk(wl_n == w0 + 3, "R4", "basic write count", 32'(wl_n - w0), 3);
        for (int i = 0; i < 3; i++) begin
            chk(wl_addr[w0+i] == UBASE + 32'h5_0000 + 32'(4 * i), "R5", "basic write addr",
                wl_addr[w0+i], UBASE + 32'h5_0000 + 32'(4 * i));
            chk(wl_data[w0+i] == 32'hA000_0000 + 32'(i), "R4", "basic write data",
                wl_data[w0+i], 32'hA000_0000 + 32'(i));
        end
        chk(busy == 0, "R8", "idle after done", 32'(busy), 0);
    endtask

    task automatic t_extra_masks;
        int b, d0, w0;
        cfg_slot_bytes = 32'h40;
        cfg_unit_shift = 5'd12;
        lat = 3;
        b = (5 * 32'h40) / 4;
        qmem[b]   = mk_hdr(6, 2, 0);
        qmem[b+1] = (32'h1 << 9) | (32'h1 << 3);
        qmem[b+2] = 32'hFFFF_FFFF;
        qmem[b+3] = 32'hFFFF_FFFF;
        qmem[b+4] = 32'hC000_0010;
        qmem[b+5] = 32'hC000_0011;
        qmem[b+6] = 32'hC000_0012;
        d0 = n_done; w0 = wl_n;
        trig(8'd5);
        wait_ends(n_done + n_err + 1);
        chk(n_done == d0 + 1, "R2", "extra-mask done (slot size 0x40)", 32'(n_done - d0), 1);
        chk(wl_n == w0 + 3, "R4", "extra-mask write count", 32'(wl_n - w0), 3);
        for (int i = 0; i < 3; i++) begin
            chk(wl_addr[w0+i] == UBASE + 32'h3000 + 32'(4 * i), "R5", "lowest mask bit addr",
                wl_addr[w0+i], UBASE + 32'h3000 + 32'(4 * i));
            chk(wl_data[w0+i] == 32'hC000_0010 + 32'(i), "R4", "map starts after extra masks",
                wl_data[w0+i], 32'hC000_0010 + 32'(i));
        end
        lat = 0;
        cfg_slot_bytes = 32'h80;
        cfg_unit_shift = 5'd16;
    endtask

    task automatic t_empty;
        int d0, e0, w0;
        qmem[6 * 32]     = mk_hdr(1, 0, 0);
        qmem[6 * 32 + 1] = 32'h1;
        qmem[7 * 32]     = mk_hdr(1, 2, 0);
        qmem[7 * 32 + 1] = 32'h1;
        d0 = n_done; e0 = n_err; w0 = wl_n;
        trig(8'd6);
        wait_ends(d0 + e0 + 1);
        chk(n_done == d0 + 1 && wl_n == w0, "R7", "zero-length: done, no write",
            32'(wl_n - w0), 0);
        trig(8'd7);
        wait_ends(d0 + e0 + 2);
        chk(n_done == d0 + 2 && wl_n == w0, "R4", "count below masks clamps to zero",
            32'(wl_n - w0), 0);
        chk(n_err == e0, "R4", "no error on empty map", 32'(n_err - e0), 0);
    endtask

    task automatic t_faults;
        int d0, e0, w0;
        qmem[8 * 32]     = mk_hdr(4, 0, 0);
        qmem[8 * 32 + 1] = 32'h0;
        qmem[9 * 32]     = mk_hdr(4, 0, 1);
        qmem[9 * 32 + 1] = 32'h1;
        d0 = n_done; e0 = n_err; w0 = wl_n;
        trig(8'd8);
        wait_ends(d0 + e0 + 1);
        chk(n_err == e0 + 1 && n_done == d0, "R6", "zero mask raises error", 32'(n_err - e0), 1);
        chk(wl_n == w0, "R6", "zero mask writes nothing", 32'(wl_n - w0), 0);
        trig(8'd9);
        wait_ends(d0 + e0 + 2);
        chk(n_err == e0 + 2 && n_done == d0, "R3", "opcode 1 raises error", 32'(n_err - e0), 2);
        chk(wl_n == w0, "R3", "opcode 1 writes nothing", 32'(wl_n - w0), 0);
    endtask

    task automatic t_pending;
        int d0, e0, w0;
        clear_slot(0, 128); clear_slot(1, 128); clear_slot(3, 128);
        qmem[0]  = mk_hdr(2, 0, 0);  qmem[1]  = 32'h1;       qmem[2] = 32'h5000_0000;
        qmem[32] = mk_hdr(3, 0, 0);  qmem[33] = 32'h1 << 1;
        qmem[34] = 32'h5100_0000;    qmem[35] = 32'h5100_0001;
        qmem[96] = mk_hdr(2, 0, 0);  qmem[97] = 32'h1 << 7;  qmem[98] = 32'h5300_0000;
        d0 = n_done; e0 = n_err; w0 = wl_n;
        @(negedge clk);
        trig_valid = 1'b1; trig_slot = 8'd0;
        @(negedge clk);
        trig_slot = 8'd1;
        @(negedge clk);
        trig_slot = 8'd3;
        @(negedge clk);
        trig_valid = 1'b0;
        wait_ends(d0 + e0 + 2);
        repeat (40) @(negedge clk);
        chk(n_done == d0 + 2, "R9", "held trigger ran, third dropped", 32'(n_done - d0), 2);
        chk(wl_n == w0 + 3, "R9", "writes from two commands", 32'(wl_n - w0), 3);
        chk(wl_data[w0] == 32'h5000_0000 && wl_addr[w0] == UBASE, "R9", "first command first",
            wl_data[w0], 32'h5000_0000);
        chk(wl_addr[w0+2] == UBASE + 32'h1_0004, "R9", "held command to unit 1",
            wl_addr[w0+2], UBASE + 32'h1_0004);
    endtask

    task automatic t_disabled;
        int d0, e0, w0, r0;
        cfg_enable = 1'b0;
        d0 = n_done; e0 = n_err; w0 = wl_n; r0 = n_rdreq;
        saw_busy = 0;
        trig(8'd2);
        repeat (30) @(negedge clk);
        chk(!saw_busy && n_rdreq == r0, "R1", "disabled trigger: no busy, no read",
            32'(n_rdreq - r0), 0);
        chk(n_done == d0 && n_err == e0 && wl_n == w0, "R1", "disabled trigger: no result",
            32'(n_done - d0 + n_err - e0), 0);
        cfg_enable = 1'b1;
        trig(8'd2);
        wait_ends(d0 + e0 + 1);
        chk(n_done == d0 + 1, "R1", "re-enabled trigger runs", 32'(n_done - d0), 1);
        chk(n_rdreq == r0 + 5, "R2", "reads: header, mask, three words",
            32'(n_rdreq - r0), 5);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) qmem[i] = 32'h0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        cfg_enable = 1'b1;
        @(negedge clk);
        t_basic();
        t_extra_masks();
        t_empty();
        t_faults();
        t_pending();
        t_disabled();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait (cyc > 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule